// File: doc/BRIEF.md
# I2C register byte transaction sequencer

This block runs single-byte register reads and writes against an I2C target. A caller gives a 7-bit device address, a register offset and, for a write, a data byte. The sequencer turns the request into a series of commands for a separate bit-level engine: start, write one bit, sample one bit, release the data line, pulse the clock, stop. The engine owns all line timing and reports back, per command, that it finished, whether a driven level failed to appear on the bus, and the sampled bit.

A read addresses the target for writing, sends the offset, then issues a repeated start and addresses it again for reading. It samples one byte and answers it with a not-acknowledge. Any failed drive or missing acknowledge ends the attempt. A recovery sequence then frees a target that may be holding the data line low. Another attempt follows after a programmable backoff, up to a separate try limit for reads and for writes. At the end the caller gets a one-cycle completion pulse, a pass/fail flag, the number of attempts used and, for reads, the sampled byte. A bit-bang enable output stays high for the whole operation so that surrounding logic can hand the pins to the engine.

Top module: `i2cx_xact`

## Requirements
- R1: After reset `busy_o`, `done_o`, `bb_en_o` and `cmd_valid_o` are low.
- R2: A write issues START, address byte with bit 0 clear, ack sample, offset byte, ack sample, data byte, ack sample, STOP. A command is held on `cmd_valid_o`/`cmd_op_o`/`cmd_bit_o` until `cmd_done_i` pulses; the next command appears in the following cycle.
- R3: A read issues START, address byte with bit 0 clear, ack sample, offset byte, ack sample, START, address byte with bit 0 set, ack sample, eight bit samples, a written 1 (not-acknowledge), STOP. The eight samples form the result, the first one being the most significant bit.
- R4: Command codes on `cmd_op_o` are START=0, STOP=1, WRITE_BIT=2 (value on `cmd_bit_o`), SAMPLE_BIT=3, RELEASE=4, CLOCK_PULSE=5. A byte is sent as eight WRITE_BIT commands, most significant bit first, followed by one RELEASE.
- R5: A `cmd_err_i` on any command of an attempt, or a sampled 1 in an ack slot, aborts the attempt at once. The recovery sequence follows: START, RELEASE, nine CLOCK_PULSE, START, STOP. Errors reported during recovery are ignored.
- R6: When another attempt follows a recovery, `cmd_valid_o` stays low for exactly BACKOFF_CYCLES+1 cycles between the recovery STOP's completion and the retry's START.
- R7: A read is tried at most RD_TRIES (default 10) times, a write at most WR_TRIES (default 1) times. When the last permitted attempt fails, the operation ends with `ok_o` low after its recovery sequence and without a backoff.
- R8: `bb_en_o` is high from the cycle after a request is accepted until the operation completes. `done_o` pulses for one cycle with `bb_en_o` already low.
- R9: `rdata_o` is cleared when a read is accepted and loaded with the sampled byte only when the read succeeds. A write leaves it unchanged.
- R10: `req_i` is ignored while `busy_o` is high.
- R11: `attempts_o` at completion equals the number of attempts started (1 for a first-try success).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an operation (taken when idle) |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| dev_i | input | 7 | Target device address |
| off_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Final status, 1 = success |
| attempts_o | output | TRY_W | Attempts used |
| rdata_o | output | 8 | Read result |
| bb_en_o | output | 1 | Bit-bang enable for the pins |
| cmd_valid_o | output | 1 | Command presented to the bit engine |
| cmd_op_o | output | 3 | Command code |
| cmd_bit_o | output | 1 | Bit value for WRITE_BIT |
| cmd_done_i | input | 1 | Engine finished the presented command |
| cmd_err_i | input | 1 | Driven level was not seen on the bus |
| cmd_rbit_i | input | 1 | Sampled bit for SAMPLE_BIT |

## Verification
The abort of an attempt and the exhaustion of the try budget can be decided on the same ack sample. On the last permitted try, the sequencer must still run the recovery sequence and then finish with a failure, skipping the backoff. The bench provokes this by having the modelled target refuse the address exactly RD_TRIES times, and one time fewer. It judges the result by the returned attempt count and status, by the absence of any further START after the final recovery, and by the measured quiet gap before each retry.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_STOP    = 3'd1,
    OP_WBIT    = 3'd2,
    OP_RBIT    = 3'd3,
    OP_RELEASE = 3'd4,
    OP_PULSE   = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    K_START, K_WBYTE, K_ACK, K_RBYTE, K_NACK, K_STOP, K_RELEASE, K_PULSE, K_END
  } kind_e;

  typedef enum logic [1:0] {B_ADDR_W, B_ADDR_R, B_OFF, B_DATA} bsel_e;

  typedef struct packed {
    kind_e kind;
    bsel_e bsel;
  } step_t;

  typedef enum logic [2:0] {S_IDLE, S_XFER, S_CLEAR, S_BACKOFF, S_DONE} st_e;
endpackage

// File: rtl/i2cx_prog.sv
module i2cx_prog
  import i2cx_pkg::*;
#(
  parameter int BYTE_BITS  = 8,
  parameter int CLR_PULSES = 9,
  parameter int IDX_W      = 4,
  parameter int LEN_W      = 4
) (
  input  logic             clear_mode_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] idx_i,
  output step_t            step_o,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    step_o = '{kind: K_END, bsel: B_ADDR_W};
    if (clear_mode_i) begin
      unique case (idx_i)
        IDX_W'(0): step_o.kind = K_START;
        IDX_W'(1): step_o.kind = K_RELEASE;
        IDX_W'(2): step_o.kind = K_PULSE;
        IDX_W'(3): step_o.kind = K_START;
        IDX_W'(4): step_o.kind = K_STOP;
        default:   step_o.kind = K_END;
      endcase
    end else if (rd_i) begin
      unique case (idx_i)
        IDX_W'(0):  step_o.kind = K_START;
        IDX_W'(1):  step_o = '{kind: K_WBYTE, bsel: B_ADDR_W};
        IDX_W'(2):  step_o.kind = K_ACK;
        IDX_W'(3):  step_o = '{kind: K_WBYTE, bsel: B_OFF};
        IDX_W'(4):  step_o.kind = K_ACK;
        IDX_W'(5):  step_o.kind = K_START;   // repeated start
        IDX_W'(6):  step_o = '{kind: K_WBYTE, bsel: B_ADDR_R};
        IDX_W'(7):  step_o.kind = K_ACK;
        IDX_W'(8):  step_o.kind = K_RBYTE;
        IDX_W'(9):  step_o.kind = K_NACK;
        IDX_W'(10): step_o.kind = K_STOP;
        default:    step_o.kind = K_END;
      endcase
    end else begin
      unique case (idx_i)
        IDX_W'(0): step_o.kind = K_START;
        IDX_W'(1): step_o = '{kind: K_WBYTE, bsel: B_ADDR_W};
        IDX_W'(2): step_o.kind = K_ACK;
        IDX_W'(3): step_o = '{kind: K_WBYTE, bsel: B_OFF};
        IDX_W'(4): step_o.kind = K_ACK;
        IDX_W'(5): step_o = '{kind: K_WBYTE, bsel: B_DATA};
        IDX_W'(6): step_o.kind = K_ACK;
        IDX_W'(7): step_o.kind = K_STOP;
        default:   step_o.kind = K_END;
      endcase
    end
  end

  // number of engine commands each step expands to
  always_comb begin
    unique case (step_o.kind)
      K_WBYTE: len_o = LEN_W'(BYTE_BITS + 1);  // bits plus line release
      K_RBYTE: len_o = LEN_W'(BYTE_BITS);
      K_PULSE: len_o = LEN_W'(CLR_PULSES);
      default: len_o = LEN_W'(1);
    endcase
  end
endmodule

// File: rtl/i2cx_phase_ctr.sv
module i2cx_phase_ctr #(
  parameter int IDX_W = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [LEN_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o <= '0;
      cnt_o <= '0;
    end else if (clr_i) begin
      idx_o <= '0;
      cnt_o <= '0;
    end else if (adv_i) begin
      if (cnt_o == len_i - LEN_W'(1)) begin
        cnt_o <= '0;
        idx_o <= idx_o + IDX_W'(1);
      end else begin
        cnt_o <= cnt_o + LEN_W'(1);
      end
    end
  end

  p_cnt_in_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> cnt_o < len_i)
    else $error("p_cnt_in_len_r4");
endmodule

// File: rtl/i2cx_backoff.sv
module i2cx_backoff #(
  parameter int CYCLES = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic fire_o
);
  localparam int W = $clog2(CYCLES + 1);
  localparam logic [W-1:0] LAST = W'(CYCLES - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end

  assign fire_o = run_i && (cnt_q == LAST);

  p_backoff_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= LAST)
    else $error("p_backoff_bound_r6");
endmodule

// File: rtl/i2cx_xact.sv
module i2cx_xact
  import i2cx_pkg::*;
#(
  parameter int RD_TRIES       = 10,
  parameter int WR_TRIES       = 1,
  parameter int BACKOFF_CYCLES = 10_000_000,
  parameter int CLR_PULSES     = 9,
  localparam int MAX_TRIES     = (RD_TRIES > WR_TRIES) ? RD_TRIES : WR_TRIES,
  localparam int TRY_W         = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_rd_i,
  input  logic [6:0]       dev_i,
  input  logic [7:0]       off_i,
  input  logic [7:0]       wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ok_o,
  output logic [TRY_W-1:0] attempts_o,
  output logic [7:0]       rdata_o,
  output logic             bb_en_o,
  output logic             cmd_valid_o,
  output logic [2:0]       cmd_op_o,
  output logic             cmd_bit_o,
  input  logic             cmd_done_i,
  input  logic             cmd_err_i,
  input  logic             cmd_rbit_i
);
  localparam int BYTE_BITS = 8;
  localparam int IDX_W     = 4;
  localparam int MAX_LEN   = (CLR_PULSES > BYTE_BITS + 1) ? CLR_PULSES : BYTE_BITS + 1;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);
  localparam logic [TRY_W-1:0] RD_LIM = TRY_W'(RD_TRIES);
  localparam logic [TRY_W-1:0] WR_LIM = TRY_W'(WR_TRIES);

  st_e              st_q;
  logic             rd_q, ok_q;
  logic [6:0]       dev_q;
  logic [7:0]       off_q, wd_q, rx_q, rdata_q;
  logic [TRY_W-1:0] tries_q;

  step_t            step;
  logic [LEN_W-1:0] len;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] cnt;
  logic             run, cmd_adv, xfer_err, ph_clr, bk_fire;
  logic [7:0]       tx_byte;
  op_e              op;
  logic             obit;

  i2cx_prog #(
    .BYTE_BITS (BYTE_BITS),
    .CLR_PULSES(CLR_PULSES),
    .IDX_W     (IDX_W),
    .LEN_W     (LEN_W)
  ) u_prog (
    .clear_mode_i(st_q == S_CLEAR),
    .rd_i        (rd_q),
    .idx_i       (idx),
    .step_o      (step),
    .len_o       (len)
  );

  i2cx_phase_ctr #(
    .IDX_W(IDX_W),
    .LEN_W(LEN_W)
  ) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ph_clr),
    .adv_i (cmd_adv && !xfer_err),
    .len_i (len),
    .idx_o (idx),
    .cnt_o (cnt)
  );

  i2cx_backoff #(
    .CYCLES(BACKOFF_CYCLES)
  ) u_backoff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (st_q == S_BACKOFF),
    .fire_o(bk_fire)
  );

  always_comb begin
    unique case (step.bsel)
      B_ADDR_W: tx_byte = {dev_q, 1'b0};
      B_ADDR_R: tx_byte = {dev_q, 1'b1};
      B_OFF:    tx_byte = off_q;
      default:  tx_byte = wd_q;
    endcase
  end

  always_comb begin
    op   = OP_START;
    obit = 1'b0;
    unique case (step.kind)
      K_START:   op = OP_START;
      K_STOP:    op = OP_STOP;
      K_ACK,
      K_RBYTE:   op = OP_RBIT;
      K_NACK:    begin op = OP_WBIT; obit = 1'b1; end
      K_RELEASE: op = OP_RELEASE;
      K_PULSE:   op = OP_PULSE;
      K_WBYTE: begin
        if (cnt == LEN_W'(BYTE_BITS)) op = OP_RELEASE;
        else begin
          op   = OP_WBIT;
          obit = tx_byte[3'd7 - cnt[2:0]];  // MSB first
        end
      end
      default:   op = OP_START;
    endcase
  end

  assign run      = (st_q == S_XFER) || (st_q == S_CLEAR);
  assign cmd_valid_o = run && (step.kind != K_END);
  assign cmd_op_o  = op;
  assign cmd_bit_o = obit;
  assign cmd_adv  = cmd_valid_o && cmd_done_i;
  assign xfer_err = (st_q == S_XFER) && cmd_adv &&
                    (cmd_err_i || ((step.kind == K_ACK) && cmd_rbit_i));
  assign ph_clr   = !run || xfer_err || ((st_q == S_CLEAR) && (step.kind == K_END));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      rd_q    <= 1'b0;
      ok_q    <= 1'b0;
      dev_q   <= '0;
      off_q   <= '0;
      wd_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
      tries_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          rd_q    <= req_rd_i;
          dev_q   <= dev_i;
          off_q   <= off_i;
          wd_q    <= wdata_i;
          ok_q    <= 1'b0;
          tries_q <= TRY_W'(1);
          if (req_rd_i) rdata_q <= '0;
          st_q    <= S_XFER;
        end
        S_XFER: begin
          if (cmd_adv && step.kind == K_RBYTE) rx_q <= {rx_q[6:0], cmd_rbit_i};
          if (xfer_err) st_q <= S_CLEAR;
          else if (step.kind == K_END) begin
            ok_q <= 1'b1;
            if (rd_q) rdata_q <= rx_q;
            st_q <= S_DONE;
          end
        end
        S_CLEAR: if (step.kind == K_END) begin
          if (tries_q < (rd_q ? RD_LIM : WR_LIM)) st_q <= S_BACKOFF;
          else begin
            ok_q <= 1'b0;
            st_q <= S_DONE;
          end
        end
        S_BACKOFF: if (bk_fire) begin
          tries_q <= tries_q + TRY_W'(1);
          st_q    <= S_XFER;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != S_IDLE);
  assign bb_en_o    = run || (st_q == S_BACKOFF);
  assign done_o     = (st_q == S_DONE);
  assign ok_o       = ok_q;
  assign attempts_o = tries_q;
  assign rdata_o    = rdata_q;

  p_cmd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_bit_o))
    else $error("p_cmd_hold_r2");

  p_try_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (attempts_o != '0) && (attempts_o <= (rd_q ? RD_LIM : WR_LIM)))
    else $error("p_try_bound_r7");

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !cmd_valid_o)
    else $error("p_done_pulse_r8");

  p_rdata_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_i && req_rd_i |=> rdata_o == '0)
    else $error("p_rdata_clr_r9");

  p_req_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o)
    else $error("p_req_ignored_r10");
endmodule

// File: tb/i2cx_xact_bench.sv
module i2cx_xact_bench;
  localparam int BK  = 20;
  localparam int TW  = 4;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, req_rd = 1'b0;
  logic [6:0] dev = '0;
  logic [7:0] off = '0, wd = '0;
  logic busy, done, ok, bb_en, cmd_valid, cmd_bit;
  logic [TW-1:0] att;
  logic [7:0] rdata;
  logic [2:0] cmd_op;
  logic cmd_done = 1'b0, cmd_err = 1'b0, cmd_rbit = 1'b0;

  always #10 clk = ~clk;

  i2cx_xact #(.BACKOFF_CYCLES(BK)) u_i2cx_xact (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .req_rd_i(req_rd),
    .dev_i(dev), .off_i(off), .wdata_i(wd),
    .busy_o(busy), .done_o(done), .ok_o(ok), .attempts_o(att), .rdata_o(rdata),
    .bb_en_o(bb_en), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_bit_o(cmd_bit),
    .cmd_done_i(cmd_done), .cmd_err_i(cmd_err), .cmd_rbit_i(cmd_rbit));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input logic c, input string tag, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- target + engine model ----------------
  logic [7:0] mem [256];
  int inj_nack = 0, inj_err = 0;
  logic [7:0] m_sr = '0, m_ptr = '0;
  int m_cnt = 0, m_phase = 0;
  logic m_tx = 1'b0;
  int trace_q[$];
  logic e_busy = 1'b0;
  int e_lat = 0;
  logic p_err = 1'b0, p_rb = 1'b0;
  int lowrun = 0;

  task automatic model_cmd(input logic [2:0] o, input logic b, output logic er, output logic rb);
    er = 1'b0; rb = 1'b1;
    case (o)
      3'd0: begin m_cnt = 0; m_phase = 0; m_tx = 1'b0; end
      3'd1: m_tx = 1'b0;
      3'd2: begin
        if (inj_err > 0) begin inj_err--; er = 1'b1; end
        else if (!m_tx) begin m_sr = {m_sr[6:0], b}; m_cnt++; end
      end
      3'd3: begin
        if (m_tx) begin
          rb = mem[m_ptr][7 - m_cnt];
          m_cnt++;
          if (m_cnt == 8) begin m_tx = 1'b0; m_cnt = 0; end
        end else if (m_cnt == 8) begin
          m_cnt = 0;
          if (m_phase == 0) begin
            if (m_sr[7:1] == DEV && inj_nack == 0) begin
              rb = 1'b0; m_phase = 1;
              if (m_sr[0]) begin m_tx = 1'b1; m_phase = 3; end
            end else begin
              if (m_sr[7:1] == DEV) inj_nack--;
              m_phase = 3;
            end
          end else if (m_phase == 1) begin m_ptr = m_sr; rb = 1'b0; m_phase = 2; end
          else if (m_phase == 2) begin mem[m_ptr] = m_sr; rb = 1'b0; m_phase = 3; end
        end
      end
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    if (!rst_ni) begin
      e_busy = 1'b0; cmd_done = 1'b0; lowrun = 0;
    end else begin
      cmd_done = 1'b0; cmd_err = 1'b0; cmd_rbit = 1'b0;
      if (e_busy) begin
        if (e_lat == 0) begin
          cmd_done = 1'b1; cmd_err = p_err; cmd_rbit = p_rb; e_busy = 1'b0;
        end else e_lat--;
      end else if (cmd_valid) begin
        trace_q.push_back(cmd_op * 2 + ((cmd_op == 3'd2) ? int'(cmd_bit) : 0));
        model_cmd(cmd_op, cmd_bit, p_err, p_rb);
        e_busy = 1'b1; e_lat = 1;
      end
      // R6 quiet gap before a retry
      if (busy && !cmd_valid) lowrun++;
      else begin
        if (cmd_valid && lowrun > 0) chk(lowrun == BK + 1, "R6 backoff gap", lowrun, BK + 1);
        lowrun = 0;
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [12:0] exp_q[$];
  string tag_q[$];

  always @(negedge clk) begin
    if (rst_ni && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected completion", 1, 0);
      else begin
        logic [12:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(ok == e[12], {t, " status"}, ok, e[12]);
        chk(att == e[11:8], {"R11 attempts ", t}, att, e[11:8]);
        chk(rdata == e[7:0], {"R9 rdata ", t}, rdata, e[7:0]);
        chk(!bb_en, "R8 enable low at done", bb_en, 0);
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic issue(input logic rd, input logic [6:0] d, input logic [7:0] o, input logic [7:0] w,
                       input logic e_ok, input int e_att, input logic [7:0] e_rd, input string tag);
    @(negedge clk);
    req = 1'b1; req_rd = rd; dev = d; off = o; wd = w;
    exp_q.push_back({e_ok, 4'(e_att), e_rd});
    tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
    chk(bb_en == 1'b1, "R8 enable high while running", bb_en, 1);
    if (rd) chk(rdata == 8'h00, "R9 rdata cleared on read", rdata, 0);
  endtask

  int want_q[$];
  task automatic w_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) want_q.push_back(4 + int'(b[i]));
    want_q.push_back(8);
  endtask
  task automatic w_clear();
    want_q.push_back(0); want_q.push_back(8);
    for (int i = 0; i < 9; i++) want_q.push_back(10);
    want_q.push_back(0); want_q.push_back(2);
  endtask
  task automatic w_read(input logic [7:0] o);
    want_q.push_back(0); w_byte({DEV, 1'b0}); want_q.push_back(6);
    w_byte(o); want_q.push_back(6);
    want_q.push_back(0); w_byte({DEV, 1'b1}); want_q.push_back(6);
    for (int i = 0; i < 8; i++) want_q.push_back(6);
    want_q.push_back(5); want_q.push_back(2);
  endtask
  task automatic cmp_trace(input string tag);
    int bad = 0;
    if (trace_q.size() != want_q.size()) bad = 1;
    else for (int i = 0; i < want_q.size(); i++) if (trace_q[i] != want_q[i]) bad = 1;
    chk(bad == 0, tag, trace_q.size(), want_q.size());
    trace_q.delete(); want_q.delete();
  endtask

  // ---------------- stimulus ----------------
  logic wd_expired = 1'b0;
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bb_en && !cmd_valid, "R1 reset state",
        {busy, done, bb_en, cmd_valid}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && !bb_en && !cmd_valid, "R1 idle after reset", {busy, bb_en, cmd_valid}, 0);

    // R2 R4: clean write
    trace_q.delete();
    issue(1'b0, DEV, 8'h10, 8'hC3, 1'b1, 1, 8'h00, "R2 write");
    wait_idle();
    want_q.push_back(0); w_byte({DEV, 1'b0}); want_q.push_back(6);
    w_byte(8'h10); want_q.push_back(6); w_byte(8'hC3); want_q.push_back(6);
    want_q.push_back(2);
    cmp_trace("R2 R4 write command order");

    // R3 R4: clean read
    issue(1'b1, DEV, 8'h10, 8'h00, 1'b1, 1, 8'hC3, "R3 read");
    wait_idle();
    w_read(8'h10);
    cmp_trace("R3 R4 read command order");

    // R9: write keeps rdata
    issue(1'b0, DEV, 8'h20, 8'h3C, 1'b1, 1, 8'hC3, "R9 write keeps rdata");
    wait_idle();
    trace_q.delete();

    // R5 R6: one refused address then success
    inj_nack = 1;
    issue(1'b1, DEV, 8'h20, 8'h00, 1'b1, 2, 8'h3C, "R5 nack retry");
    wait_idle();
    want_q.push_back(0); w_byte({DEV, 1'b0}); want_q.push_back(6);
    w_clear(); w_read(8'h20);
    cmp_trace("R5 abort, recovery sequence, retry");

    // R5: drive error
    inj_err = 1;
    issue(1'b1, DEV, 8'h10, 8'h00, 1'b1, 2, 8'hC3, "R5 drive error");
    wait_idle();
    trace_q.delete();

    // R7: absent device exhausts read tries
    issue(1'b1, 7'h51, 8'h10, 8'h00, 1'b0, 10, 8'h00, "R7 read exhaust");
    wait_idle();
    chk(trace_q[trace_q.size() - 1] == 2, "R7 ends with recovery stop, no retry",
        trace_q[trace_q.size() - 1], 2);
    trace_q.delete();

    // R7: write tried once
    inj_nack = 1;
    issue(1'b0, DEV, 8'h30, 8'h77, 1'b0, 1, 8'h00, "R7 write single try");
    wait_idle();
    issue(1'b1, DEV, 8'h30, 8'h00, 1'b1, 1, 8'h95, "R7 failed write left target");
    wait_idle();

    // R7 R11: limit boundaries
    inj_nack = 9;
    issue(1'b1, DEV, 8'h10, 8'h00, 1'b1, 10, 8'hC3, "R11 success on last try");
    wait_idle();
    inj_nack = 10;
    issue(1'b1, DEV, 8'h10, 8'h00, 1'b0, 10, 8'h00, "R7 fail on last try");
    wait_idle();
    inj_nack = 0;

    // R10: request while busy
    issue(1'b1, DEV, 8'h20, 8'h00, 1'b1, 1, 8'h3C, "R10 first op");
    repeat (5) @(negedge clk);
    req = 1'b1; req_rd = 1'b0; off = 8'h20; wd = 8'hEE;
    @(negedge clk);
    req = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(!busy, "R10 no second operation", busy, 0);
    issue(1'b1, DEV, 8'h20, 8'h00, 1'b1, 1, 8'h3C, "R10 target untouched");
    wait_idle();

    if (!wd_expired) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    wd_expired = 1'b1;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule